// File: doc/BRIEF.md
# Reset Control Register

This block is a single byte-wide control register that sits on a narrow I/O request channel and lets software ask for a reset. It answers at one fixed port address. A write sets the stored byte and can start a reset. A read returns the stored byte in a response. Two outputs carry the reset request to the reset generators: `cpu_reset_o` asks for a processor-only reset, and `sys_reset_o` asks for a full platform reset. `sys_reset_o` also tells the configuration-access decoder to go back to its default access mechanism.

Bit 2 of the byte (the trigger bit) starts a reset. A reset starts only when a write sets bit 2 while the stored copy of bit 2 is clear. Bit 1 (the full-reset select) picks the kind of reset. It is never stored. When bit 1 is set in a write, the stored trigger bit is also cleared, so the next write can trigger again. Reads never show the trigger bit.

The request channel uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each read that hits the port gives exactly one response on a valid/ready response channel. The block holds only one response at a time. While that response waits for `rsp_ready`, `req_ready` stays low, and this stalls writes as well as reads. Requests to any other address are accepted, have no effect and get no response.

Top module: `rst_ctrl_reg`

## Requirements
- R1: After reset the stored byte is 0x00, no reset output is high, no response is pending, `req_ready` is high, and the first read of the port returns 0x00.
- R2: A reset pulse starts only when an accepted write to the port has bit 2 set and the stored bit 2 is 0. A write with bit 2 set while the stored bit 2 is already 1 starts nothing.
- R3: When a triggering write also has bit 1 set, both `sys_reset_o` and `cpu_reset_o` pulse together. When bit 1 is clear, only `cpu_reset_o` pulses.
- R4: An accepted write to the port stores the written byte with bit 1 forced to 0.
- R5: When the written byte has bit 1 set, the stored bit 2 becomes 0. A later write with bit 2 set can then trigger again.
- R6: A read response carries the stored byte with bit 2 forced to 0.
- R7: A reset pulse is high for exactly the one cycle that follows the clock edge that accepted the triggering write. Non-triggering writes update the stored byte and raise no pulse.
- R8: Requests to any address other than the port address change nothing, raise no pulse and produce no response.
- R9: A pending response keeps `rsp_valid` high and `rsp_rdata` stable until `rsp_ready` is seen. `req_ready` is low while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | I/O port address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 8 | Read response byte |
| cpu_reset_o | output | 1 | One-cycle processor reset request |
| sys_reset_o | output | 1 | One-cycle full reset request, also resets the configuration mechanism |

## Verification
Writes are sent in several sequences. One sets bit 2 from a cleared state, which triggers. One repeats bit 2 while it is still stored, which does not trigger. One uses bit 1 to clear the hidden bit 2 and then triggers again. One sends back-to-back full-reset writes. These sequences separate a design that detects the 0-to-1 change from one that triggers on the level, and a design that clears bit 2 on a bit-1 write from one that does not. Because the stored trigger bit is never read back, the bench observes it only through whether the next write triggers. Mixed-bit patterns such as 0xF5 and 0xFB check the bit-1 and bit-2 masking of reads. Writes and reads to nearby addresses check that only the port address decodes. A response consumer that stalls shows whether data holds and whether requests are blocked while a response waits.

// File: rtl/rcr_pkg.sv
`timescale 1ns/1ps
package rcr_pkg;
  // Pair of reset requests issued by a triggering write.
  typedef struct packed {
    logic full;  // platform-wide reset
    logic cpu;   // processor reset
  } rst_req_t;
endpackage

// File: rtl/rcr_decode.sv
`timescale 1ns/1ps
module rcr_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'hCF9
) (
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic fire;
  logic match;

  assign fire   = req_valid && req_ready;
  assign match  = (req_addr == PORT_ADDR);
  assign wr_hit = fire && match && req_write;
  assign rd_hit = fire && match && !req_write;
endmodule

// File: rtl/rcr_core.sv
`timescale 1ns/1ps
module rcr_core
  import rcr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TRIG_BIT = 2,
  parameter int FULL_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stored,
  output rst_req_t          pulse
);
  logic [DATA_W-1:0] next_val;
  logic              arm_edge;

  // Value kept after a write: select bit dropped, trigger bit dropped too
  // whenever the select bit accompanies it.
  always_comb begin
    next_val           = wdata;
    next_val[FULL_BIT] = 1'b0;
    if (wdata[FULL_BIT]) next_val[TRIG_BIT] = 1'b0;
  end

  assign arm_edge = wdata[TRIG_BIT] && !stored[TRIG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored <= '0;
      pulse  <= '0;
    end else begin
      pulse <= '0;
      if (wr_en) begin
        stored <= next_val;
        if (arm_edge) begin
          pulse.cpu  <= 1'b1;
          pulse.full <= wdata[FULL_BIT];
        end
      end
    end
  end

  assert_trigger_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse.cpu |-> $past(wr_en && wdata[TRIG_BIT]));

  assert_full_with_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse.full |-> pulse.cpu);

  assert_select_not_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stored[FULL_BIT]);

  assert_select_clears_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[FULL_BIT]) |=> !stored[TRIG_BIT]);
endmodule

// File: rtl/rcr_rsp.sv
`timescale 1ns/1ps
module rcr_rsp #(
  parameter int DATA_W   = 8,
  parameter int TRIG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] src,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] masked;

  // Read view: the trigger bit never shows.
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b == TRIG_BIT) begin : g_hide
      assign masked[b] = 1'b0;
    end else begin : g_pass
      assign masked[b] = src[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (load) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= masked;
      end
    end
  end

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_read_hides_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_rdata[TRIG_BIT]);
endmodule

// File: rtl/rst_ctrl_reg.sv
`timescale 1ns/1ps
module rst_ctrl_reg
  import rcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'hCF9,
  parameter int TRIG_BIT = 2,
  parameter int FULL_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  output logic              cpu_reset_o,
  output logic              sys_reset_o
);
  localparam int DATA_W = 8;

  logic              wr_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] stored;
  rst_req_t          pulse;

  assign req_ready = !rsp_valid;

  rcr_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit)
  );

  rcr_core #(.DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT), .FULL_BIT(FULL_BIT)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_hit),
    .wdata  (req_wdata),
    .stored (stored),
    .pulse  (pulse)
  );

  rcr_rsp #(.DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_hit),
    .src       (stored),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign cpu_reset_o = pulse.cpu;
  assign sys_reset_o = pulse.full;

  assert_pulse_follows_port_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset_o |-> $past(req_valid && req_ready && req_write && (req_addr == PORT_ADDR)));

  assert_foreign_no_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && !req_write && (req_addr == PORT_ADDR)));

  assert_stall_blocks_requests_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/test_rst_ctrl_reg.sv
`timescale 1ns/1ps
module test_rst_ctrl_reg;
  localparam logic [15:0] PORT = 16'hCF9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_rdata;
  logic        cpu_reset_o;
  logic        sys_reset_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rst_ctrl_reg i_rst_ctrl_reg (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cpu_reset_o(cpu_reset_o), .sys_reset_o(sys_reset_o)
  );

  // Scoreboard queues
  logic [1:0] pq[$];   // {sys, cpu} expected after each port write
  string      ptag[$];
  logic [7:0] rq[$];
  string      rtag[$];
  logic [7:0] model = 8'h00;
  bit         stall_mode = 1'b0;
  bit         done = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [15:0] a, input logic [7:0] d);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    bit trig;
    if (a == PORT) begin
      trig = d[2] && !model[2];
      pq.push_back({trig && d[1], trig});
      ptag.push_back(tag);
      model = d & 8'hFD;
      if (d[1]) model[2] = 1'b0;
    end
    drive(1'b1, a, d);
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    if (a == PORT) begin
      rq.push_back(model & 8'hFB);
      rtag.push_back(tag);
    end
    drive(1'b0, a, 8'h00);
  endtask

  // Response consumer: stalls two of every three cycles in stall mode
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    #1 rsp_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // Monitor: sampled at the falling edge
  bit         pend_wr = 1'b0;
  bit         prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_wr) begin
        if (pq.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R7: actual pulse with empty queue expected none");
        end else begin
          check(ptag.pop_front(), {6'b0, sys_reset_o, cpu_reset_o}, {6'b0, pq.pop_front()});
        end
      end else if (cpu_reset_o || sys_reset_o) begin
        check("R7 no pulse without port write", {6'b0, sys_reset_o, cpu_reset_o}, 8'h00);
      end
      if (rsp_valid && prev_stall) begin
        check("R9 data held under stall", rsp_rdata, prev_data);
        check("R9 ready low while pending", {7'b0, req_ready}, 8'h00);
      end
      if (rsp_valid && rsp_ready) begin
        if (rq.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R8: actual response %02h expected none", rsp_rdata);
        end else begin
          check(rtag.pop_front(), rsp_rdata, rq.pop_front());
        end
      end
      prev_stall = rsp_valid && !rsp_ready;
      prev_data  = rsp_rdata;
      pend_wr = req_valid && req_ready && req_write && (req_addr == PORT);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 cpu reset idle", {7'b0, cpu_reset_o}, 8'h00);
    check("R1 sys reset idle", {7'b0, sys_reset_o}, 8'h00);
    check("R1 no response", {7'b0, rsp_valid}, 8'h00);
    check("R1 ready", {7'b0, req_ready}, 8'h01);
    @(posedge clk); #1;
    do_read(PORT, "R1 reset value");

    do_write(PORT, 8'h04, "R2 R3 cpu-only trigger");
    do_read(PORT, "R6 trigger bit hidden");
    do_write(PORT, 8'h04, "R2 no retrigger while set");
    do_write(PORT, 8'hF5, "R2 still set, no pulse");
    do_read(PORT, "R4 R6 F5 readback");
    do_write(PORT, 8'h06, "R5 select clears stored trigger");
    do_write(PORT, 8'h04, "R5 trigger again after clear");
    do_write(PORT, 8'h00, "R7 plain write no pulse");
    do_write(PORT, 8'h06, "R3 full reset");
    do_write(PORT, 8'h06, "R3 R5 back-to-back full reset");
    do_write(PORT, 8'hFB, "R4 select dropped, no trigger");
    do_read(PORT, "R4 FB readback");

    do_write(16'hCF8, 8'h04, "R8 foreign");
    do_write(16'hCFA, 8'h00, "R8 foreign");
    do_read(16'hCF8, "R8 foreign read");
    do_read(PORT, "R8 unchanged after foreign");
    do_write(PORT, 8'h00, "R7 plain write");
    do_write(16'h0CF9 ^ 16'h1000, 8'h06, "R8 aliased address");
    do_write(PORT, 8'h04, "R8 trigger proves state untouched");

    stall_mode = 1'b1;
    do_read(PORT, "R9 stalled read 1");
    do_write(PORT, 8'h02, "R9 write behind pending response");
    do_read(PORT, "R9 stalled read 2");
    do_write(PORT, 8'hA8, "R9 write behind pending response 2");
    do_read(PORT, "R9 stalled read 3");
    repeat (10) @(posedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);

    check("R8 R9 all responses seen", 8'(rq.size()), 8'h00);
    check("R7 all pulses seen", 8'(pq.size()), 8'h00);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule